// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block produces the reset outputs for a processor, for the peripherals and for the shared external reset pin. Software asks for a reset with a keyed write on a fast master-clock register port. It can select any mix of processor reset, peripheral reset and external-pin reset. The selected internal resets assert on the master clock straight away. Their duration and release are then timed on a slow clock, so release always happens on a slow-clock edge.

A brownout flag and a low level on the external pin from an outside source are hardware reset sources. Both are resynchronised on the slow clock before release. The processor reset is held a few slow cycles longer than the peripheral reset, which gives the processor a startup delay. A mode register sets how long the block drives the external pin low. The pin level that the block itself causes is masked, so its own pulse never counts as an outside reset.

A status field reports the cause of the last reset. A busy flag shows that a software reset is in progress, and command writes are refused while it is set. The power-on reset `rst_n` is synchronous and active low, and it is sampled in each clock domain. The slow clock is assumed to be at least four times slower than the master clock.

Top module: `sysrst_ctrl`

## Requirements
- R1: After `rst_n` is released, `per_rst_n` goes high after the second slow-clock edge. `proc_rst_n` goes high three slow edges later. `cause` reads 0 (power-up), `busy` reads 0 and `pin_drv_n` reads 1.
- R2: A command write has `wr_en`=1, `wr_sel`=0 and `wr_data[31:24]`=0xA5. Bit 0 requests processor reset, bit 1 peripheral reset and bit 2 external-pin reset. The selected internal outputs go low in the master-clock cycle after the write.
- R3: A software reset holds its selected outputs low for 3 slow cycles after a 2-edge resync. For a write made before slow edge E1, the outputs stay low through E5 and go high at E6.
- R4: A command or mode write whose `wr_data[31:24]` is not 0xA5 is ignored: no output changes.
- R5: `busy` goes high on an accepted command and clears only after the reset period and any pin pulse have ended. Command writes made while `busy` is high are ignored.
- R6: A mode write has `wr_sel`=1, the 0xA5 key and length L in `wr_data[3:0]`. A later external-reset command drives `pin_drv_n` low for exactly 2^(L+1) slow cycles.
- R7: The low pin level caused by the block's own pulse is not taken as a user reset. `cause`, `proc_rst_n` and `per_rst_n` are unaffected.
- R8: `cause` becomes 3 (software) only when the command includes the processor bit. A command without it leaves `cause` unchanged.
- R9: While `bod_i` is high, both internal resets are low at once and `cause` becomes 5. After `bod_i` falls, `per_rst_n` rises at the second slow edge and `proc_rst_n` rises three slow edges later.
- R10: A low level on `pin_i` that the block is not driving asserts both internal resets and sets `cause` to 4 (user).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mck | input | 1 | Fast master clock for the register port |
| sclk | input | 1 | Slow clock for reset timing |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the command register, 1 the mode register |
| wr_data | input | 32 | Write data: key in [31:24], command bits or length field |
| bod_i | input | 1 | Brownout flag, active high |
| pin_i | input | 1 | Sensed level of the external reset pin |
| proc_rst_n | output | 1 | Processor and watchdog reset, active low |
| per_rst_n | output | 1 | Peripheral reset, active low |
| pin_drv_n | output | 1 | External pin driver, low drives the pin low |
| cause | output | 3 | Last reset cause: 0 power-up, 3 software, 4 user, 5 brownout |
| busy | output | 1 | Software reset in progress |

## Verification
A lost or stale request handshake shows at the ports in one of two ways. `busy` either never clears, or it clears while a reset output is still low. Either is visible within about eight slow cycles of the write. A wrong software-period or startup counter moves the release of `proc_rst_n` or `per_rst_n` by whole slow cycles. The bench therefore samples each reset output in the middle of every slow cycle around the expected release. A missing self-pulse mask shows up as `cause` turning to 4 within three slow cycles after the pin pulse ends.

// File: rtl/sysrst_pkg.sv
// Shared constants and types for the system reset controller.
package sysrst_pkg;
    localparam logic [7:0] WR_KEY = 8'hA5;

    typedef enum logic [2:0] {
        CAUSE_POWERUP  = 3'd0,
        CAUSE_SOFT     = 3'd3,
        CAUSE_USER     = 3'd4,
        CAUSE_BROWNOUT = 3'd5
    } cause_e;

    // Command bits as they sit in the low bits of a command write.
    typedef struct packed {
        logic ext;
        logic per;
        logic proc;
    } cmd_t;
endpackage

// File: rtl/sysrst_cmd.sv
// Master-clock side: takes keyed register writes and holds a request
// level until the slow side acknowledges it (four-phase handshake).
// Assumes: the ack input comes from the slow domain, and the held command
// stays stable while the request is high.
module sysrst_cmd
    import sysrst_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 4
) (
    input  logic              mck,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ack_i,
    output logic              req_o,
    output cmd_t              cmd_o,
    output logic [LEN_W-1:0]  len_o,
    output logic              busy_o
);
    localparam int CMD_W = $bits(cmd_t);

    logic [1:0] ack_m;
    logic       key_ok;
    logic       accept;
    logic       unused_bits;

    assign key_ok      = (wr_data[DATA_W-1 -: 8] == WR_KEY);
    assign busy_o      = req_o | ack_m[1];
    assign accept      = wr_en & ~wr_sel & key_ok & (|wr_data[CMD_W-1:0]) & ~busy_o;
    assign unused_bits = ^wr_data[DATA_W-9:CMD_W];

    // Bring the slow-domain acknowledge onto the master clock.
    always_ff @(posedge mck) begin
        if (!rst_n) ack_m <= '0;
        else        ack_m <= {ack_m[0], ack_i};
    end

    // Hold the request until it is acknowledged; accept new commands only when idle.
    always_ff @(posedge mck) begin
        if (!rst_n) begin
            req_o <= 1'b0;
            cmd_o <= '0;
        end else if (req_o && ack_m[1]) begin
            req_o <= 1'b0;
        end else if (accept) begin
            req_o <= 1'b1;
            cmd_o <= cmd_t'(wr_data[CMD_W-1:0]);
        end
    end

    // Mode register: pin pulse length field.
    always_ff @(posedge mck) begin
        if (!rst_n)                         len_o <= '0;
        else if (wr_en && wr_sel && key_ok) len_o <= wr_data[LEN_W-1:0];
    end
endmodule

// File: rtl/sysrst_soft.sv
// Slow-clock side of a software reset: resyncs the request, times the
// fixed reset period and the programmable pin pulse, and produces the
// mask that hides the block's own pin pulse from the user-reset detector.
// Assumes: req_i, cmd_i and len_i are stable while req_i is high.
module sysrst_soft
    import sysrst_pkg::*;
#(
    parameter int LEN_W  = 4,
    parameter int SW_LEN = 3
) (
    input  logic             sclk,
    input  logic             rst_n,
    input  logic             req_i,
    input  cmd_t             cmd_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             ack_o,
    output logic             sw_proc_o,
    output logic             sw_per_o,
    output logic             proc_start_o,
    output logic             pin_drv_n_o,
    output logic             mask_o
);
    localparam int EXT_W = (1 << LEN_W) + 1;
    localparam int SW_W  = $clog2(SW_LEN + 1);

    logic [1:0]       req_s;
    logic [SW_W-1:0]  sw_cnt;
    logic [EXT_W-1:0] ext_cnt;
    logic [1:0]       guard;
    logic             lat_proc, lat_per;
    logic             start;

    assign start        = req_s[1] & ~ack_o;
    assign proc_start_o = start & cmd_i.proc;
    assign sw_proc_o    = (sw_cnt != '0) & lat_proc;
    assign sw_per_o     = (sw_cnt != '0) & lat_per;
    assign pin_drv_n_o  = (ext_cnt == '0);
    assign mask_o       = (ext_cnt != '0) | (guard != '0);

    // Two-flop resync of the master-clock request.
    always_ff @(posedge sclk) begin
        if (!rst_n) req_s <= '0;
        else        req_s <= {req_s[0], req_i};
    end

    // Start, count and finish a software reset; drop ack once fully idle.
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            ack_o    <= 1'b0;
            sw_cnt   <= '0;
            ext_cnt  <= '0;
            lat_proc <= 1'b0;
            lat_per  <= 1'b0;
        end else if (start) begin
            ack_o    <= 1'b1;
            sw_cnt   <= SW_W'(SW_LEN);
            lat_proc <= cmd_i.proc;
            lat_per  <= cmd_i.per;
            if (cmd_i.ext)
                ext_cnt <= EXT_W'(1) << ({1'b0, len_i} + 1'b1);
        end else begin
            if (sw_cnt != '0)  sw_cnt  <= sw_cnt - 1'b1;
            if (ext_cnt != '0) ext_cnt <= ext_cnt - 1'b1;
            if (ack_o && sw_cnt == '0 && ext_cnt == '0 && !req_s[1])
                ack_o <= 1'b0;
        end
    end

    // Keep the mask up until the released pin level has passed the resync.
    always_ff @(posedge sclk) begin
        if (!rst_n)              guard <= '0;
        else if (ext_cnt != '0)  guard <= 2'd3;
        else if (guard != '0)    guard <= guard - 1'b1;
    end
endmodule

// File: rtl/sysrst_hw.sv
// Hardware reset sources on the slow clock: brownout and outside pin reset.
// Both assert the resets, are released through a 2-edge resync, and the
// processor reset is then held for a startup delay.
// Assumes: bod_i and pin_i are asynchronous; bod_i asserts the outputs
// without waiting for a clock.
module sysrst_hw #(
    parameter int SYNC_LEN    = 2,
    parameter int STARTUP_LEN = 3
) (
    input  logic sclk,
    input  logic rst_n,
    input  logic bod_i,
    input  logic pin_i,
    input  logic mask_i,
    output logic hw_per_o,
    output logic hw_proc_o,
    output logic bod_evt_o,
    output logic usr_evt_o
);
    localparam int SU_W = $clog2(STARTUP_LEN + 1);

    logic [1:0]          bod_s;
    logic [1:0]          pin_s;
    logic [SYNC_LEN-1:0] rel;
    logic [SU_W-1:0]     su_cnt;
    logic                src;

    assign usr_evt_o = pin_s[1] & ~mask_i;
    assign bod_evt_o = bod_s[1];
    assign src       = bod_i | usr_evt_o;
    assign hw_per_o  = src | (|rel);
    assign hw_proc_o = hw_per_o | (su_cnt != '0);

    // Resync brownout flag and inverted pin level.
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            bod_s <= '0;
            pin_s <= '0;
        end else begin
            bod_s <= {bod_s[0], bod_i};
            pin_s <= {pin_s[0], ~pin_i};
        end
    end

    // Release chain: the hold ends SYNC_LEN edges after the source clears.
    generate
        if (SYNC_LEN == 1) begin : g_rel1
            always_ff @(posedge sclk) begin
                if (!rst_n) rel <= '1;
                else        rel <= src;
            end
        end else begin : g_reln
            always_ff @(posedge sclk) begin
                if (!rst_n) rel <= '1;
                else        rel <= {rel[SYNC_LEN-2:0], src};
            end
        end
    endgenerate

    // Processor startup delay after the common hold ends.
    always_ff @(posedge sclk) begin
        if (!rst_n)              su_cnt <= SU_W'(STARTUP_LEN);
        else if (hw_per_o)       su_cnt <= SU_W'(STARTUP_LEN);
        else if (su_cnt != '0)   su_cnt <= su_cnt - 1'b1;
    end
endmodule

// File: rtl/sysrst_ctrl.sv
// Top of the system reset controller. Combines the master-clock command
// hold, the slow-clock software timer and the hardware sources into the
// reset outputs, and keeps the last-cause field on the slow clock.
// Assumes: sclk is at least four times slower than mck; the cause field
// is quasi-static and read after the event has settled.
module sysrst_ctrl
    import sysrst_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int LEN_W       = 4,
    parameter int SW_LEN      = 3,
    parameter int SYNC_LEN    = 2,
    parameter int STARTUP_LEN = 3
) (
    input  logic              mck,
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bod_i,
    input  logic              pin_i,
    output logic              proc_rst_n,
    output logic              per_rst_n,
    output logic              pin_drv_n,
    output logic [2:0]        cause,
    output logic              busy
);
    logic             req, ack;
    cmd_t             cmd;
    logic [LEN_W-1:0] len;
    logic             sw_proc, sw_per, proc_start, mask;
    logic             hw_per, hw_proc, bod_evt, usr_evt;

    sysrst_cmd #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_cmd (
        .mck(mck), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ack_i(ack), .req_o(req), .cmd_o(cmd),
        .len_o(len), .busy_o(busy)
    );

    sysrst_soft #(.LEN_W(LEN_W), .SW_LEN(SW_LEN)) u_soft (
        .sclk(sclk), .rst_n(rst_n), .req_i(req), .cmd_i(cmd), .len_i(len),
        .ack_o(ack), .sw_proc_o(sw_proc), .sw_per_o(sw_per),
        .proc_start_o(proc_start), .pin_drv_n_o(pin_drv_n), .mask_o(mask)
    );

    sysrst_hw #(.SYNC_LEN(SYNC_LEN), .STARTUP_LEN(STARTUP_LEN)) u_hw (
        .sclk(sclk), .rst_n(rst_n), .bod_i(bod_i), .pin_i(pin_i),
        .mask_i(mask), .hw_per_o(hw_per), .hw_proc_o(hw_proc),
        .bod_evt_o(bod_evt), .usr_evt_o(usr_evt)
    );

    assign proc_rst_n = ~((req & cmd.proc) | sw_proc | hw_proc);
    assign per_rst_n  = ~((req & cmd.per)  | sw_per  | hw_per);

    // Record the last cause: brownout over user pin over software.
    always_ff @(posedge sclk) begin
        if (!rst_n)          cause <= CAUSE_POWERUP;
        else if (bod_evt)    cause <= CAUSE_BROWNOUT;
        else if (usr_evt)    cause <= CAUSE_USER;
        else if (proc_start) cause <= CAUSE_SOFT;
    end
endmodule

// File: rtl/sysrst_ctrl_chk.sv
// Property checker for sysrst_ctrl, attached by bind. Observes ports only.
module sysrst_ctrl_chk (
    input logic        mck,
    input logic        sclk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_sel,
    input logic [31:0] wr_data,
    input logic        bod_i,
    input logic        proc_rst_n,
    input logic        per_rst_n,
    input logic        pin_drv_n,
    input logic [2:0]  cause,
    input logic        busy
);
    AST_BOD_HOLDS_RESETS: assert property (@(posedge mck) disable iff (!rst_n)
        bod_i |-> (!per_rst_n && !proc_rst_n)); // R9

    AST_PROC_CMD_ASSERTS: assert property (@(posedge mck) disable iff (!rst_n)
        (wr_en && !wr_sel && wr_data[31:24] == 8'hA5 && wr_data[0] && !busy) |=> !proc_rst_n); // R2

    AST_PIN_MIN_WIDTH: assert property (@(posedge sclk) disable iff (!rst_n)
        $fell(pin_drv_n) |=> !pin_drv_n); // R6

    AST_PIN_WHILE_BUSY: assert property (@(posedge mck) disable iff (!rst_n)
        !pin_drv_n |-> busy); // R5

    AST_CAUSE_LEGAL: assert property (@(posedge mck) disable iff (!rst_n)
        cause inside {3'd0, 3'd3, 3'd4, 3'd5}); // R8
endmodule

bind sysrst_ctrl sysrst_ctrl_chk u_chk (.*);

// File: tb/sysrst_ctrl_test.sv
// Directed bench for sysrst_ctrl: one task per scenario, sampled mid slow cycle.
module sysrst_ctrl_test;
    logic        mck = 1'b0, sclk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0, bod_i = 1'b0, usr_n = 1'b1;
    logic [31:0] wr_data = '0;
    logic        proc_rst_n, per_rst_n, pin_drv_n, busy, pin_i;
    logic [2:0]  cause;
    int          checks = 0, errors = 0;

    assign pin_i = pin_drv_n & usr_n;

    sysrst_ctrl uut (
        .mck(mck), .sclk(sclk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .bod_i(bod_i), .pin_i(pin_i),
        .proc_rst_n(proc_rst_n), .per_rst_n(per_rst_n), .pin_drv_n(pin_drv_n),
        .cause(cause), .busy(busy)
    );

    always #4 mck = ~mck;
    initial begin
        #2;
        forever #32 sclk = ~sclk;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic mid();
        @(posedge sclk);
        #16;
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge mck);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge mck);
        wr_en = 1'b0; wr_data = '0;
        #1;
    endtask

    task automatic t_reset();
        @(posedge sclk); #16;
        rst_n = 1'b1;
        mid(); // E1
        chk("R1 per held E1", per_rst_n, 0);
        mid(); // E2
        chk("R1 per released E2", per_rst_n, 1);
        chk("R1 proc held E2", proc_rst_n, 0);
        mid(); mid(); // E4
        chk("R1 proc held E4", proc_rst_n, 0);
        mid(); // E5
        chk("R1 proc released E5", proc_rst_n, 1);
        chk("R1 cause power-up", cause, 0);
        chk("R1 busy idle", busy, 0);
        chk("R1 pin idle", pin_drv_n, 1);
    endtask

    task automatic t_nokey();
        @(posedge sclk);
        wr(1'b0, 32'h5A00_0007);
        chk("R4 busy stays low", busy, 0);
        for (int k = 0; k < 6; k++) begin
            mid();
            chk("R4 no reset without key", {proc_rst_n, per_rst_n, pin_drv_n}, 3'b111);
        end
    endtask

    task automatic t_bod();
        @(posedge sclk); #16;
        bod_i = 1'b1;
        #1;
        chk("R9 immediate assert", {proc_rst_n, per_rst_n}, 2'b00);
        mid(); mid(); mid();
        chk("R9 cause brownout", cause, 5);
        bod_i = 1'b0;
        mid(); // E1
        chk("R9 per held E1", per_rst_n, 0);
        mid(); // E2
        chk("R9 per released E2", per_rst_n, 1);
        chk("R9 proc held E2", proc_rst_n, 0);
        mid(); mid(); // E4
        chk("R9 proc held E4", proc_rst_n, 0);
        mid(); // E5
        chk("R9 proc released E5", proc_rst_n, 1);
    endtask

    task automatic t_per_only();
        @(posedge sclk);
        wr(1'b0, 32'hA500_0002);
        chk("R2 per asserted next cycle", per_rst_n, 0);
        for (int k = 0; k < 9; k++) begin
            mid();
            chk("R8 proc untouched by per-only", proc_rst_n, 1);
        end
        chk("R8 cause kept without proc bit", cause, 5);
        chk("R3 per released", per_rst_n, 1);
    endtask

    task automatic t_sw_proc();
        @(posedge sclk);
        wr(1'b0, 32'hA500_0003);
        chk("R2 proc asserted next cycle", proc_rst_n, 0);
        chk("R2 per asserted next cycle", per_rst_n, 0);
        chk("R5 busy set", busy, 1);
        wr(1'b0, 32'hA500_0004); // refused while busy
        for (int k = 1; k <= 6; k++) begin
            mid();
            if (k <= 5) chk("R3 held in period", {proc_rst_n, per_rst_n}, 2'b00);
            else        chk("R3 released at E6", {proc_rst_n, per_rst_n}, 2'b11);
            chk("R5 refused command drives no pin", pin_drv_n, 1);
        end
        chk("R8 cause software", cause, 3);
        mid(); mid();
        chk("R5 busy cleared", busy, 0);
        for (int k = 0; k < 4; k++) begin
            mid();
            chk("R5 refused command stays refused", pin_drv_n, 1);
        end
    endtask

    task automatic t_ext(input logic [3:0] len, input int exp_low);
        int lows = 0;
        @(posedge sclk);
        wr(1'b1, {8'hA5, 20'h0, len});
        wr(1'b0, 32'hA500_0004);
        for (int k = 0; k < exp_low + 12; k++) begin
            mid();
            if (!pin_drv_n) lows++;
            if (!proc_rst_n || !per_rst_n) begin
                checks++; errors++;
                $display("FAIL R7 internal reset during own pulse actual=0 expected=1");
            end
        end
        chk("R6 pin pulse length", lows, exp_low);
        chk("R7 cause unchanged by own pulse", cause, 3);
        chk("R5 busy cleared after pulse", busy, 0);
    endtask

    task automatic t_user();
        @(posedge sclk); #16;
        usr_n = 1'b0;
        mid(); mid(); mid(); mid();
        chk("R10 user reset asserts", {proc_rst_n, per_rst_n}, 2'b00);
        chk("R10 cause user", cause, 4);
        usr_n = 1'b1;
        for (int k = 0; k < 8; k++) mid();
        chk("R10 released after pin high", {proc_rst_n, per_rst_n}, 2'b11);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge mck);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        t_nokey();
        t_bod();
        t_per_only();
        t_sw_proc();
        t_ext(4'd2, 8);
        t_ext(4'd0, 2);
        t_user();
        finish_run();
    end
endmodule